// File: doc/BRIEF.md
# Change-Triggered Interrupt Message Aggregator

This block gathers eleven interrupt request lines and turns a change on any enabled line into a single memory write toward the processor. Bits 0 to 5 carry the six downstream bus interrupt lines, bit 6 an external interrupt and bit 10 a serial port interrupt. Each line is synchronized and compared with its previous synchronized value. A change in either direction on an enabled line latches a pending bit, so a line that is already high when it is enabled raises nothing.

Software reaches the block through a small register port. It programs a message target word, which holds the write address in its upper bits and the data word in its low bits. It enables lines with a mask, and it collects events through two read-to-clear registers. A separate live-level register always shows the synchronized input states. When an enabled event occurs while the message port is idle, the block issues one write and holds it until it is acknowledged. Events that arrive while that write is outstanding are folded into at most one follow-up write.

Top module: `chgirq_msg_agg`

## Requirements
- R1: Each input passes through two flops. The live-level register (offset 0x028, bits 10:0) reads the synchronized inputs, and reading any register never changes it.
- R2: A change in either direction on input i with mask bit i set sets pending bit i. The change must be present at clock edge N, the pending bit is readable after edge N+2, and it is set in the same edge that the message write starts.
- R3: The mask register (offset 0x018, bits 10:0, 1 = enabled) resets to zero. A change on a masked line sets nothing. Setting a mask bit while its line is already high raises no event.
- R4: A read of the request register (offset 0x00C) returns the pending bits ANDed with 0x5FF and clears those bits in the same access. Bit 9 always reads zero.
- R5: A read of the pending register (offset 0x01C) returns all eleven pending bits and clears them. An event that arrives in the same cycle as the clearing read is kept.
- R6: The target register (offset 0x004) is 32 bits read/write. The message address is the target with its low 5 bits cleared, and the message data is those low 5 bits, zero-extended.
- R7: An enabled event while idle raises msgValid one cycle after the event is detected. msgValid, msgAddr and msgData hold steady until a cycle with msgValid and msgAck both high.
- R8: After an acknowledge, msgValid is low for at least one cycle. Exactly one further write follows, one cycle later, if an enabled event arrived while the write was outstanding (the acknowledge cycle included); otherwise the port goes idle. msgAddr and msgData read zero while msgValid is low.
- R9: After reset the mask, pending bits and target are zero and msgValid is low.
- R10: A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 11 | Asynchronous interrupt request lines |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; clears read-to-clear registers at the clock edge |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid in the cycle of regRdEn |
| msgValid | output | 1 | Message write request |
| msgAddr | output | 32 | Message write address |
| msgData | output | 32 | Message write data |
| msgAck | input | 1 | Message write acknowledge |

## Verification
The bench goes after the enable-while-high case. A design that detected levels instead of changes would issue a spurious message there. It checks that falling edges count as events, since a rising-only detector would miss them. It also checks that bit 9 is blanked in the request register but kept in the pending register, and that a clearing read does not drop an event arriving in the same cycle. Events raised during an outstanding write must produce exactly one follow-up write after a gap. A design that coalesced wrongly would either drop that write or stream repeated ones. Holding msgAck low for many cycles exposes a message port that changes its address or data before the acknowledge.

// File: rtl/chgirq_pkg.sv
package chgirq_pkg;
  localparam int unsigned IRQ_W     = 11;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned MSG_BITS  = 5;
  localparam logic [IRQ_W-1:0] IMPL_MASK = 11'h5FF;

  localparam logic [ADDR_W-1:0] OFF_TGT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_REQ  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_MASK = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_PEND = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_LVL  = 12'h028;

  typedef struct packed {
    logic loadMsg;
    logic dropMsg;
  } msgStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_REARM = 2'd2
  } msgState_t;
endpackage

// File: rtl/chgirq_datapath.sv
module chgirq_datapath
  import chgirq_pkg::*;
#(
  parameter int unsigned NIRQ   = IRQ_W,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned LOWB   = MSG_BITS,
  parameter logic [NIRQ-1:0] IMPL = IMPL_MASK
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NIRQ-1:0] irqIn,
  input  logic            regWrEn,
  input  logic            regRdEn,
  input  logic [AW-1:0]   regAddr,
  input  logic [DW-1:0]   regWrData,
  output logic [DW-1:0]   regRdData,
  input  msgStrobe_t      strobe,
  output logic            evtAny,
  output logic [DW-1:0]   msgAddr,
  output logic [DW-1:0]   msgData
);
  localparam int unsigned PADW = DW - NIRQ;
  localparam logic [DW-1:0] LOW_MASK = {{(DW-LOWB){1'b0}}, {LOWB{1'b1}}};

  logic [NIRQ-1:0] syncA, syncB, syncPrev;
  logic [NIRQ-1:0] maskQ, pendQ, changeEvt, clrVec;
  logic [DW-1:0]   tgtQ, msgAddrQ, msgDataQ;
  logic            wrMask, wrTgt, rdReq, rdPend;

  // two-flop synchronizer plus one history stage for change detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= irqIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign changeEvt = (syncB ^ syncPrev) & maskQ;
  assign evtAny    = |changeEvt;

  assign wrMask = regWrEn && (regAddr == OFF_MASK);
  assign wrTgt  = regWrEn && (regAddr == OFF_TGT);
  assign rdReq  = regRdEn && (regAddr == OFF_REQ);
  assign rdPend = regRdEn && (regAddr == OFF_PEND);

  assign clrVec = ({NIRQ{rdReq}} & IMPL) | {NIRQ{rdPend}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      tgtQ  <= '0;
    end else begin
      if (wrMask) maskQ <= regWrData[NIRQ-1:0];
      if (wrTgt)  tgtQ  <= regWrData;
    end
  end

  // one pending cell per line; a new event wins over a clearing read
  for (genvar i = 0; i < NIRQ; i++) begin : g_pend
    logic bitQ;
    always_ff @(posedge clk) begin
      if (!rstN) bitQ <= 1'b0;
      else       bitQ <= (bitQ & ~clrVec[i]) | changeEvt[i];
    end
    assign pendQ[i] = bitQ;
  end

  // message word capture, held until the controller drops it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddrQ <= '0;
      msgDataQ <= '0;
    end else if (strobe.loadMsg) begin
      msgAddrQ <= tgtQ & ~LOW_MASK;
      msgDataQ <= tgtQ & LOW_MASK;
    end else if (strobe.dropMsg) begin
      msgAddrQ <= '0;
      msgDataQ <= '0;
    end
  end

  assign msgAddr = msgAddrQ;
  assign msgData = msgDataQ;

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        OFF_TGT:  regRdData = tgtQ;
        OFF_REQ:  regRdData = {{PADW{1'b0}}, pendQ & IMPL};
        OFF_MASK: regRdData = {{PADW{1'b0}}, maskQ};
        OFF_PEND: regRdData = {{PADW{1'b0}}, pendQ};
        OFF_LVL:  regRdData = {{PADW{1'b0}}, syncB};
        default:  regRdData = '0;
      endcase
    end
  end

  // R3: a newly set pending bit must have been enabled in the cycle before
  a_r3_mask_gates: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(maskQ)) == '0));

  // R5: after a pending read only events of that same cycle survive
  a_r5_pend_cleared: assert property (@(posedge clk) disable iff (!rstN)
    rdPend |=> ((pendQ & ~$past(changeEvt)) == '0));

  // R4: unimplemented request bits read zero
  a_r4_bit9_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> ((regRdData[NIRQ-1:0] & ~IMPL) == '0));
endmodule

// File: rtl/chgirq_ctrl.sv
module chgirq_ctrl
  import chgirq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtAny,
  input  logic       msgAck,
  output logic       msgValid,
  output msgStrobe_t strobe
);
  msgState_t stateQ, stateN;
  logic      extraQ, extraN;

  always_comb begin
    stateN = stateQ;
    extraN = extraQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: begin
        if (evtAny) begin
          stateN         = ST_SEND;
          strobe.loadMsg = 1'b1;
        end
      end
      ST_SEND: begin
        if (msgAck) begin
          strobe.dropMsg = 1'b1;
          extraN         = 1'b0;
          stateN         = (extraQ || evtAny) ? ST_REARM : ST_IDLE;
        end else if (evtAny) begin
          extraN = 1'b1;
        end
      end
      ST_REARM: begin
        stateN         = ST_SEND;
        strobe.loadMsg = 1'b1;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      extraQ <= 1'b0;
    end else begin
      stateQ <= stateN;
      extraQ <= extraN;
    end
  end

  assign msgValid = (stateQ == ST_SEND);

  // R8: a request only ends through an acknowledge
  a_r8_fall_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(msgValid) |-> $past(msgAck));

  // R8: an acknowledged request is followed by a low cycle
  a_r8_gap_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgAck) |=> !msgValid);
endmodule

// File: rtl/chgirq_msg_agg.sv
module chgirq_msg_agg
  import chgirq_pkg::*;
#(
  parameter int unsigned NIRQ = IRQ_W,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned LOWB = MSG_BITS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NIRQ-1:0] irqIn,
  input  logic            regWrEn,
  input  logic            regRdEn,
  input  logic [AW-1:0]   regAddr,
  input  logic [DW-1:0]   regWrData,
  output logic [DW-1:0]   regRdData,
  output logic            msgValid,
  output logic [DW-1:0]   msgAddr,
  output logic [DW-1:0]   msgData,
  input  logic            msgAck
);
  msgStrobe_t strobe;
  logic       evtAny;

  chgirq_datapath #(
    .NIRQ(NIRQ), .AW(AW), .DW(DW), .LOWB(LOWB), .IMPL(IMPL_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .evtAny(evtAny),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  chgirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evtAny(evtAny), .msgAck(msgAck),
    .msgValid(msgValid), .strobe(strobe)
  );

  // R7: the request and its payload stay put until acknowledged
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgAck) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));
endmodule

// File: tb/chgirq_msg_agg_test.sv
module chgirq_msg_agg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] irqIn = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, msgAck = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, msgAddr, msgData;
  logic        msgValid;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  chgirq_msg_agg uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData),
    .msgAck(msgAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [10:0] inHist[$] = '{11'd0, 11'd0, 11'd0};
  logic [10:0] mMask = '0, mPend = '0;
  logic [31:0] mTgt = '0, mAddr = '0, mData = '0;
  int          mPhase = 0;  // 0 idle, 1 sending, 2 gap before resend
  bit          mExtra = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      inHist = '{11'd0, 11'd0, 11'd0};
      mMask = '0; mPend = '0; mTgt = '0; mAddr = '0; mData = '0;
      mPhase = 0; mExtra = 0;
    end else begin
      logic [10:0] evt, clr;
      bit trig;
      evt  = (inHist[1] ^ inHist[0]) & mMask;
      trig = (evt != 0);
      clr  = '0;
      if (regRdEn && regAddr == 12'h00C) clr = 11'h5FF;
      if (regRdEn && regAddr == 12'h01C) clr = 11'h7FF;
      mPend = (mPend & ~clr) | evt;
      case (mPhase)
        0: if (trig) begin
             mPhase = 1; mAddr = mTgt & 32'hFFFF_FFE0; mData = mTgt & 32'h1F;
           end
        1: if (msgAck) begin
             mAddr = '0; mData = '0;
             mPhase = (mExtra || trig) ? 2 : 0;
             mExtra = 0;
           end else if (trig) mExtra = 1;
        default: begin
             mPhase = 1; mAddr = mTgt & 32'hFFFF_FFE0; mData = mTgt & 32'h1F;
           end
      endcase
      if (regWrEn && regAddr == 12'h018) mMask = regWrData[10:0];
      if (regWrEn && regAddr == 12'h004) mTgt = regWrData;
      inHist.push_back(irqIn);
      void'(inHist.pop_front());
    end
  end

  function automatic logic [31:0] expRead(logic [11:0] a);
    case (a)
      12'h004: return mTgt;
      12'h00C: return {21'd0, mPend & 11'h5FF};
      12'h018: return {21'd0, mMask};
      12'h01C: return {21'd0, mPend};
      12'h028: return {21'd0, inHist[1]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // message port compared every cycle (R7 R8)
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R7/R8 msgValid", {31'd0, msgValid}, {31'd0, mPhase == 1});
      check("R6/R7 msgAddr", msgAddr, mAddr);
      check("R6/R7 msgData", msgData, mData);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(logic [11:0] a, string req);
    regRdEn = 1; regAddr = a;
    #1;
    check(req, regRdData, expRead(a));
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    for (int k = 0; k < 50 && !msgValid; k++) @(negedge clk);
    msgAck = 1;
    @(negedge clk);
    msgAck = 0;
  endtask

  initial begin
    idle(3);
    rstN = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 valid", {31'd0, msgValid}, 32'd0);
    rd(12'h018, "R9 mask");
    rd(12'h01C, "R9 pend");
    rd(12'h004, "R9 tgt");
    // R6 target
    wr(12'h004, 32'hABCD_1237);
    rd(12'h004, "R6 tgt readback");
    // R3 masked change is ignored, R1 level still visible
    irqIn[0] = 1; idle(4);
    rd(12'h01C, "R3 masked no pend");
    rd(12'h028, "R1 level");
    rd(12'h028, "R1 level not cleared");
    check("R3 no msg", {31'd0, msgValid}, 32'd0);
    // R3 enabling while high raises nothing
    wr(12'h018, 32'h7FF); idle(4);
    rd(12'h01C, "R3 enable while high");
    check("R3 no msg after enable", {31'd0, msgValid}, 32'd0);
    // R2 rising edge on bit 3, R7 hold without ack
    irqIn[3] = 1; @(negedge clk);
    rd(12'h01C, "R2 not yet");
    idle(1);
    rd(12'h00C, "R2 R4 request read");
    idle(8);
    // R8 events during outstanding write
    irqIn[10] = 1; irqIn[5] = 1; idle(4);
    ack();
    idle(3);
    ack();
    idle(5);
    check("R8 idle after resend", {31'd0, msgValid}, 32'd0);
    rd(12'h00C, "R4 request clears");
    rd(12'h01C, "R5 pending after request");
    // R4 bit 9 blanked, R5 kept in pending; falling edge counts (R2)
    irqIn[9] = 1; irqIn[0] = 0; idle(4);
    rd(12'h00C, "R4 bit9 zero");
    rd(12'h01C, "R5 bit9 present");
    rd(12'h01C, "R5 cleared");
    ack(); idle(3);
    // R5 clearing read in the same cycle as a new event
    irqIn[1] = 1; idle(1);
    rd(12'h01C, "R5 read near event");
    rd(12'h01C, "R5 event kept");
    idle(2); ack(); idle(3);
    // R10 unmapped
    rd(12'h100, "R10 unmapped");
    rd(12'h008, "R10 unmapped low");
    // R3 mask off line 2
    wr(12'h018, 32'h7FB); irqIn[2] = 1; idle(5);
    rd(12'h01C, "R3 masked line");
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      failCnt++;
      testCnt++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule